// File: doc/BRIEF.md
# Funnel Shifter for Logical, Arithmetic and Rotate Shifts

This block is a purely combinational N-bit shifter. Every shift it offers is produced by the same right-shifting funnel. The funnel joins an upper half and a lower half into a 2N-bit word and returns the N-bit window that starts at a chosen offset. Each operation differs only in what it feeds into the two halves and in how the offset is worked out from the shift amount.

A small control module decodes the operation code into a struct of strobes. The strobes pick the source of the upper half (zero, replicated sign, or operand), decide whether the lower half is cleared, decide whether the offset is negated, and request a pass-through. A datapath module builds the word and runs it through a cascade of log2(N) levels of 2:1 multiplexers, one level per offset bit. The block suits an execution unit that needs all four shift kinds behind a single operation select. N must be a power of two.

Top module: `funnelShift`

## Requirements
- R1: With opSel = 2'b01 (logical right), result equals opA shifted right by shAmt, and the top shAmt bits are 0.
- R2: With opSel = 2'b10 (arithmetic right), result equals opA shifted right by shAmt, and the top shAmt bits are copies of opA[N-1].
- R3: With opSel = 2'b11 (rotate right), result bit i equals opA[(i+shAmt) mod N], so no bits are lost and the count of ones is unchanged.
- R4: With opSel = 2'b00 (logical left), result equals opA shifted left by shAmt, and the low shAmt bits are 0.
- R5: With shAmt = 0, result equals opA for every one of the four operations.
- R6: With shAmt = N-1, left shift leaves only bit N-1 (taken from opA[0]), logical right leaves only bit 0 (taken from opA[N-1]), and arithmetic right gives all bits equal to opA[N-1].
- R7: The block has no storage: result follows a change on opA, shAmt or opSel with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | N | Operand to be shifted |
| shAmt | input | log2(N) | Shift distance, 0 to N-1 |
| opSel | input | 2 | 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right |
| result | output | N | Shifted operand |

## Verification
Two things can act in the same evaluation: the negated offset that left shifts use, and the pass-through taken when the shift distance is zero. A left shift by zero would otherwise wrap the offset to N and yield zero. The bench provokes this by applying a left shift with distance zero straight after a left shift by one and after a rotate on the same operand, then comparing the result with the unchanged operand. It also sweeps every distance for each operation on operands with the sign bit set and clear, and compares against a model built from the language's own shift operators.

// File: rtl/funnelShiftPkg.sv
package funnelShiftPkg;

  typedef enum logic [1:0] {
    OP_SLL = 2'b00,
    OP_SRL = 2'b01,
    OP_SRA = 2'b10,
    OP_ROR = 2'b11
  } shiftOp_e;

  typedef enum logic [1:0] {
    UP_ZERO = 2'b00,
    UP_SIGN = 2'b01,
    UP_OPND = 2'b10
  } upperSrc_e;

  // Strobes from control to datapath
  typedef struct packed {
    upperSrc_e upperSrc;   // what fills the upper half of the funnel
    logic      lowerZero;  // clear the lower half instead of the operand
    logic      negateAmt;  // offset = N - shAmt instead of shAmt
    logic      passThru;   // return the operand unchanged
  } shiftCtrl_t;

endpackage

// File: rtl/funnelStage.sv
module funnelStage #(
  parameter int WIDTH = 64,
  parameter int SHIFT = 1
) (
  input  logic [WIDTH-1:0] din,
  input  logic             sel,
  output logic [WIDTH-1:0] dout
);
  always_comb begin
    dout = sel ? (din >> SHIFT) : din;
  end
endmodule

// File: rtl/funnelShiftCtrl.sv
module funnelShiftCtrl
  import funnelShiftPkg::*;
#(
  parameter int N  = 32,
  localparam int SW = $clog2(N)
) (
  input  logic [1:0]    opSel,
  input  logic [SW-1:0] shAmt,
  output shiftCtrl_t    strobes
);
  always_comb begin
    strobes = '{upperSrc: UP_ZERO, lowerZero: 1'b0, negateAmt: 1'b0, passThru: 1'b0};
    unique case (shiftOp_e'(opSel))
      OP_SLL: begin
        strobes.upperSrc  = UP_OPND;
        strobes.lowerZero = 1'b1;
        strobes.negateAmt = 1'b1;
        strobes.passThru  = (shAmt == '0);
      end
      OP_SRL: strobes.upperSrc = UP_ZERO;
      OP_SRA: strobes.upperSrc = UP_SIGN;
      OP_ROR: strobes.upperSrc = UP_OPND;
      default: strobes.upperSrc = UP_ZERO;
    endcase
  end
endmodule

// File: rtl/funnelShiftDp.sv
module funnelShiftDp
  import funnelShiftPkg::*;
#(
  parameter int N  = 32,
  localparam int SW = $clog2(N),
  localparam int W2 = 2 * N
) (
  input  logic [N-1:0]  opA,
  input  logic [SW-1:0] shAmt,
  input  shiftCtrl_t    strobes,
  output logic [N-1:0]  result
);
  logic [N-1:0]  upperHalf;
  logic [N-1:0]  lowerHalf;
  logic [SW-1:0] offset;
  logic [W2-1:0] levelWord [SW+1];

  always_comb begin
    unique case (strobes.upperSrc)
      UP_SIGN: upperHalf = {N{opA[N-1]}};
      UP_OPND: upperHalf = opA;
      default: upperHalf = '0;
    endcase
    lowerHalf = strobes.lowerZero ? '0 : opA;
    // N is a power of two, so N - shAmt wraps to the two's complement
    offset    = strobes.negateAmt ? (SW'(0) - shAmt) : shAmt;
  end

  assign levelWord[0] = {upperHalf, lowerHalf};

  for (genvar lvl = 0; lvl < SW; lvl++) begin : g_level
    funnelStage #(.WIDTH(W2), .SHIFT(1 << lvl)) stageInst (
      .din (levelWord[lvl]),
      .sel (offset[lvl]),
      .dout(levelWord[lvl+1])
    );
  end

  assign result = strobes.passThru ? opA : levelWord[SW][N-1:0];
endmodule

// File: rtl/funnelShift.sv
module funnelShift
  import funnelShiftPkg::*;
#(
  parameter int N  = 32,
  localparam int SW = $clog2(N)
) (
  input  logic [N-1:0]  opA,
  input  logic [SW-1:0] shAmt,
  input  logic [1:0]    opSel,
  output logic [N-1:0]  result
);
  shiftCtrl_t strobes;

  funnelShiftCtrl #(.N(N)) ctrlInst (
    .opSel  (opSel),
    .shAmt  (shAmt),
    .strobes(strobes)
  );

  funnelShiftDp #(.N(N)) dpInst (
    .opA    (opA),
    .shAmt  (shAmt),
    .strobes(strobes),
    .result (result)
  );
endmodule

// File: rtl/funnelShiftChk.sv
module funnelShiftChk #(
  parameter int N  = 32,
  localparam int SW = $clog2(N)
) (
  input logic [N-1:0]  opA,
  input logic [SW-1:0] shAmt,
  input logic [1:0]    opSel,
  input logic [N-1:0]  result
);
  logic [N-1:0] topMask;
  logic [N-1:0] lowMask;

  always_comb begin
    topMask = ~({N{1'b1}} >> shAmt);
    lowMask = ~({N{1'b1}} << shAmt);
    // R1
    srl_fill_chk: assert (opSel != 2'b01 || (result & topMask) == '0)
      else $error("logical right fill not zero");
    // R2
    sra_fill_chk: assert (opSel != 2'b10 ||
                          (result & topMask) == (opA[N-1] ? topMask : '0))
      else $error("arithmetic right fill not sign");
    // R3
    ror_ones_chk: assert (opSel != 2'b11 || $countones(result) == $countones(opA))
      else $error("rotate lost bits");
    // R4
    sll_fill_chk: assert (opSel != 2'b00 || (result & lowMask) == '0)
      else $error("left shift fill not zero");
    // R5
    zero_amt_chk: assert (shAmt != '0 || result == opA)
      else $error("zero distance changed operand");
  end
endmodule

bind funnelShift funnelShiftChk #(.N(N)) chkInst (
  .opA   (opA),
  .shAmt (shAmt),
  .opSel (opSel),
  .result(result)
);

// File: tb/funnelShift_test.sv
`timescale 1ns/1ps
module funnelShift_test;
  localparam int N  = 32;
  localparam int SW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  opA = '0;
  logic [SW-1:0] shAmt = '0;
  logic [1:0]    opSel = 2'b00;
  logic [N-1:0]  result;
  int            nChecks = 0;
  int            nFails  = 0;
  bit            done    = 1'b0;

  always #5 clk = ~clk;

  funnelShift #(.N(N)) uut (
    .opA(opA), .shAmt(shAmt), .opSel(opSel), .result(result)
  );

  function automatic logic [N-1:0] model(input logic [1:0] op,
                                         input logic [N-1:0] a,
                                         input int k);
    logic [2*N-1:0] dbl;
    case (op)
      2'b00: return a << k;
      2'b01: return a >> k;
      2'b10: return $unsigned($signed(a) >>> k);
      default: begin
        dbl = {a, a} >> k;
        return dbl[N-1:0];
      end
    endcase
  endfunction

  task automatic compare(input string req, input logic [N-1:0] got,
                         input logic [N-1:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: op=%0b k=%0d a=%h got %h expected %h",
               req, opSel, shAmt, opA, got, exp);
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic [N-1:0] a, input int k);
    @(negedge clk);
    opSel = op; opA = a; shAmt = SW'(k);
    #1;
  endtask

  task automatic testReset();
    apply(2'b01, '0, 0);
    compare("R5 reset", result, '0);
  endtask

  task automatic testLogicalRight();
    apply(2'b01, 32'hF000_000F, 4);
    compare("R1", result, 32'h0F00_0000);
    apply(2'b01, 32'h8000_0001, 31);
    compare("R1", result, 32'h0000_0001);
  endtask

  task automatic testArithRight();
    apply(2'b10, 32'h8000_0000, 4);
    compare("R2", result, 32'hF800_0000);
    apply(2'b10, 32'h7000_00F0, 4);
    compare("R2", result, 32'h0700_000F);
  endtask

  task automatic testRotate();
    apply(2'b11, 32'h0000_000F, 4);
    compare("R3", result, 32'hF000_0000);
    apply(2'b11, 32'h1234_5678, 8);
    compare("R3", result, 32'h7812_3456);
  endtask

  task automatic testLeft();
    apply(2'b00, 32'h0000_00FF, 8);
    compare("R4", result, 32'h0000_FF00);
    apply(2'b00, 32'hFFFF_FFFF, 1);
    compare("R4", result, 32'hFFFF_FFFE);
  endtask

  task automatic testZeroAmt();
    for (int op = 0; op < 4; op++) begin
      apply(2'b00, 32'hA5C3_0F81, 1);
      apply(2'b11, 32'hA5C3_0F81, 3);
      apply(2'(op), 32'hA5C3_0F81, 0);
      compare("R5", result, 32'hA5C3_0F81);
    end
  endtask

  task automatic testMaxAmt();
    apply(2'b00, 32'h0000_0001, N-1);
    compare("R6 sll", result, 32'h8000_0000);
    apply(2'b01, 32'hFFFF_FFFF, N-1);
    compare("R6 srl", result, 32'h0000_0001);
    apply(2'b10, 32'h8000_0000, N-1);
    compare("R6 sra", result, 32'hFFFF_FFFF);
  endtask

  task automatic testNoClock();
    @(negedge clk);
    opSel = 2'b01; opA = 32'h8000_0000; shAmt = SW'(1);
    #1 compare("R7", result, 32'h4000_0000);
    shAmt = SW'(2);
    #1 compare("R7", result, 32'h2000_0000);
    opSel = 2'b10;
    #1 compare("R7", result, 32'hE000_0000);
  endtask

  task automatic testSweep();
    logic [N-1:0] pats [3];
    string tags [4];
    pats[0] = 32'h9E37_79B9; pats[1] = 32'h6A09_E667; pats[2] = 32'h8000_0001;
    tags[0] = "R4 sweep"; tags[1] = "R1 sweep"; tags[2] = "R2 sweep"; tags[3] = "R3 sweep";
    for (int p = 0; p < 3; p++)
      for (int op = 0; op < 4; op++)
        for (int k = 0; k < N; k++) begin
          apply(2'(op), pats[p], k);
          compare(tags[op], result, model(2'(op), pats[p], k));
        end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    testReset();
    rst = 1'b0;
    testLogicalRight();
    testArithRight();
    testRotate();
    testLeft();
    testZeroAmt();
    testMaxAmt();
    testNoClock();
    testSweep();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule